// File: doc/BRIEF.md
# LFSR Raster Timing Generator

This block produces the raster timing for a display: horizontal sync, vertical sync, a display-enable window, and two start strobes, one for each line and one for each frame. It runs on the pixel clock. Its pixel and line positions are held in 16-bit linear feedback shift registers, not in binary counters. A shift register has no carry chain, so the next-state logic stays one XOR deep at any line length.

Because the counters step through a pseudo-random sequence, software never writes a position as a plain number. For a position N, it writes the shift-register state that the counter reaches N steps after it is loaded with all ones. The block fires an event when a counter equals that state.

Software loads ten 16-bit compare values through a byte-wide write port. A separate blank input forces the display enable low and leaves the sync timing running.

Top module: `lfsr_raster_timer`

## Requirements
- R1: While reset is held, every output is low. Both counters sit at the seed 0xFFFF, and all ten compare values reset to 0xFFFF, which is the state for position 0.
- R2: Each counter step moves the state one place to the left. The new bit 0 is the XOR of the old bits 15, 4, 2 and 1. A compare value for position N is the state reached N steps after the seed.
- R3: The pixel counter advances on every clock. In the cycle after it equals the line-end compare value L(N), it holds the seed again, so a line lasts N+1 clocks. line_start_o is high exactly in the cycles where the pixel counter holds the seed, which is pixel position 0.
- R4: The line counter advances one step only when a line ends. It reloads the seed when a line ends while it equals the frame-end compare value L(M), so a frame lasts M+1 lines. frame_start_o is high in the cycles where the pixel position and the line position are both 0.
- R5: hsync_o goes high when the pixel position reaches the sync-open position. It goes low when the pixel position reaches the sync-close position. If both positions are the same, close takes priority and the pulse is empty.
- R6: vsync_o follows the same open/close rule in lines, using the vertical sync-open and sync-close positions. It is evaluated only when the line position changes.
- R7: de_o is high when the horizontal display window and the vertical display window are both open. Each window follows the open/close rule of R5, with its own open and close positions.
- R8: While blank_i is high, de_o is low in the cycle that follows. hsync_o, vsync_o and both strobes are not affected by blank_i.
- R9: The compare values are at these write addresses, high byte first: horizontal display open 0x01, horizontal display close 0x03, vertical display open 0x05, vertical display close 0x07, line end 0x09, hsync open 0x0B, hsync close 0x0D, frame end 0x11, vsync open 0x13, vsync close 0x15. A write to one of these addresses stores its byte as a pending high byte. A write to the next address up updates the whole 16-bit value at once, as {pending byte, written byte}. Writes to any other address, for example 0x0F and 0x10, have no effect.
- R10: All outputs are registered. They describe the counter positions held after the same clock edge, so the counters and the outputs never disagree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous reset, active high |
| blank_i | input | 1 | Forces display enable low while high |
| wr_en_i | input | 1 | Write strobe for the compare-value port |
| wr_addr_i | input | 8 | Byte address of the write |
| wr_data_i | input | 8 | Byte to write |
| hsync_o | output | 1 | Horizontal sync pulse |
| vsync_o | output | 1 | Vertical sync pulse |
| de_o | output | 1 | Display enable |
| line_start_o | output | 1 | High at pixel position 0 |
| frame_start_o | output | 1 | High at pixel position 0 of line position 0 |

## Verification
The hardest collision is a line ending in the same cycle that the line counter steps, while a horizontal or vertical window also opens or closes in that cycle. To provoke it, the second programmed mode opens the horizontal display at position 0 and closes it at the line-end position. It also opens the vertical display at line 0 and sets a vertical close position that the frame never reaches, and it makes the hsync open and close positions equal. A behavioural model in the bench holds binary positions and applies the open/close rules. It is compared with every output on every clock. Windowed counts of strobes, sync cycles and enabled pixels then confirm the line length, the frame length and the empty-pulse priority.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

    localparam int BYTE_W   = 8;
    localparam int REG_W    = 2 * BYTE_W;
    localparam int NUM_REGS = 10;
    localparam int NUM_WIN  = 4;

    // compare value slots
    localparam int IDX_HDISP_OPEN  = 0;
    localparam int IDX_HDISP_CLOSE = 1;
    localparam int IDX_VDISP_OPEN  = 2;
    localparam int IDX_VDISP_CLOSE = 3;
    localparam int IDX_LINE_END    = 4;
    localparam int IDX_HSYNC_OPEN  = 5;
    localparam int IDX_HSYNC_CLOSE = 6;
    localparam int IDX_FRAME_END   = 7;
    localparam int IDX_VSYNC_OPEN  = 8;
    localparam int IDX_VSYNC_CLOSE = 9;

    // window trackers
    localparam int WIN_HDISP = 0;
    localparam int WIN_HSYNC = 1;
    localparam int WIN_VDISP = 2;
    localparam int WIN_VSYNC = 3;

    typedef enum logic {
        WIN_OUT = 1'b0,
        WIN_IN  = 1'b1
    } win_state_t;

    // address of the high byte of a slot; low byte sits one above
    function automatic logic [BYTE_W-1:0] slot_addr(input int idx);
        case (idx)
            IDX_HDISP_OPEN:  slot_addr = 8'h01;
            IDX_HDISP_CLOSE: slot_addr = 8'h03;
            IDX_VDISP_OPEN:  slot_addr = 8'h05;
            IDX_VDISP_CLOSE: slot_addr = 8'h07;
            IDX_LINE_END:    slot_addr = 8'h09;
            IDX_HSYNC_OPEN:  slot_addr = 8'h0B;
            IDX_HSYNC_CLOSE: slot_addr = 8'h0D;
            IDX_FRAME_END:   slot_addr = 8'h11;
            IDX_VSYNC_OPEN:  slot_addr = 8'h13;
            IDX_VSYNC_CLOSE: slot_addr = 8'h15;
            default:         slot_addr = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/lrt_regfile.sv
module lrt_regfile
    import lrt_pkg::*;
(
    input  logic                             clk_i,
    input  logic                             rst_i,
    input  logic                             wr_en_i,
    input  logic [BYTE_W-1:0]                wr_addr_i,
    input  logic [BYTE_W-1:0]                wr_data_i,
    output logic [NUM_REGS-1:0][REG_W-1:0]   regs_o
);

    logic [BYTE_W-1:0]   pend_q;
    logic [NUM_REGS-1:0] hi_hit;
    logic [NUM_REGS-1:0] lo_hit;

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            hi_hit[i] = wr_en_i && (wr_addr_i == slot_addr(i));
            lo_hit[i] = wr_en_i && (wr_addr_i == slot_addr(i) + 8'd1);
        end
    end

    // R9: pending high byte, shared by all slots
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q <= '1;
        end else if (|hi_hit) begin
            pend_q <= wr_data_i;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                regs_o[g] <= '1;
            end else if (lo_hit[g]) begin
                regs_o[g] <= {pend_q, wr_data_i};
            end
        end
    end

endmodule

// File: rtl/lrt_axis.sv
module lrt_axis
    import lrt_pkg::*;
#(
    parameter int              W        = REG_W,
    parameter logic [W-1:0]    TAP_MASK = 16'h8016
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         step_en_i,
    input  logic [W-1:0] end_state_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cnt_next_o,
    output logic         at_end_o
);

    localparam logic [W-1:0] SEED = '1;

    logic         fb;
    logic [W-1:0] stepped;

    always_comb begin
        fb         = ^(cnt_o & TAP_MASK);
        stepped    = {cnt_o[W-2:0], fb};
        at_end_o   = (cnt_o == end_state_i);
        if (!step_en_i) begin
            cnt_next_o = cnt_o;
        end else if (at_end_o) begin
            cnt_next_o = SEED;
        end else begin
            cnt_next_o = stepped;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_o <= SEED;
        end else begin
            cnt_o <= cnt_next_o;
        end
    end

endmodule

// File: rtl/lrt_window.sv
module lrt_window
    import lrt_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         step_en_i,
    input  logic [W-1:0] next_cnt_i,
    input  logic [W-1:0] open_i,
    input  logic [W-1:0] close_i,
    output logic         in_o,
    output logic         in_next_o
);

    win_state_t state_q, state_d;
    logic       hit_open, hit_close;

    always_comb begin
        hit_open  = step_en_i && (next_cnt_i == open_i);
        hit_close = step_en_i && (next_cnt_i == close_i);
        state_d   = state_q;
        unique case (state_q)
            WIN_OUT: if (hit_open && !hit_close) state_d = WIN_IN;
            WIN_IN:  if (hit_close)              state_d = WIN_OUT;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= WIN_OUT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        in_o      = (state_q == WIN_IN);
        in_next_o = (state_d == WIN_IN);
    end

endmodule

// File: rtl/lfsr_raster_timer.sv
module lfsr_raster_timer
    import lrt_pkg::*;
#(
    parameter logic [REG_W-1:0] TAP_MASK = 16'h8016
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              blank_i,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              line_start_o,
    output logic              frame_start_o
);

    localparam logic [REG_W-1:0] SEED = '1;

    logic [NUM_REGS-1:0][REG_W-1:0] regs;
    logic [REG_W-1:0] h_cnt, h_next, v_cnt, v_next;
    logic [REG_W-1:0] xend_state, yend_state;
    logic             h_end, v_end;

    logic [NUM_WIN-1:0]            win_step, win_q, win_d;
    logic [NUM_WIN-1:0][REG_W-1:0] win_cnt, win_open, win_close;
    logic                          hdisp_on, vdisp_on;

    lrt_regfile u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .regs_o    (regs)
    );

    assign xend_state = regs[IDX_LINE_END];
    assign yend_state = regs[IDX_FRAME_END];

    lrt_axis #(.W(REG_W), .TAP_MASK(TAP_MASK)) u_hcnt (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .step_en_i   (1'b1),
        .end_state_i (xend_state),
        .cnt_o       (h_cnt),
        .cnt_next_o  (h_next),
        .at_end_o    (h_end)
    );

    lrt_axis #(.W(REG_W), .TAP_MASK(TAP_MASK)) u_vcnt (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .step_en_i   (h_end),
        .end_state_i (yend_state),
        .cnt_o       (v_cnt),
        .cnt_next_o  (v_next),
        .at_end_o    (v_end)
    );

    always_comb begin
        win_step[WIN_HDISP]  = 1'b1;
        win_cnt[WIN_HDISP]   = h_next;
        win_open[WIN_HDISP]  = regs[IDX_HDISP_OPEN];
        win_close[WIN_HDISP] = regs[IDX_HDISP_CLOSE];

        win_step[WIN_HSYNC]  = 1'b1;
        win_cnt[WIN_HSYNC]   = h_next;
        win_open[WIN_HSYNC]  = regs[IDX_HSYNC_OPEN];
        win_close[WIN_HSYNC] = regs[IDX_HSYNC_CLOSE];

        win_step[WIN_VDISP]  = h_end;
        win_cnt[WIN_VDISP]   = v_next;
        win_open[WIN_VDISP]  = regs[IDX_VDISP_OPEN];
        win_close[WIN_VDISP] = regs[IDX_VDISP_CLOSE];

        win_step[WIN_VSYNC]  = h_end;
        win_cnt[WIN_VSYNC]   = v_next;
        win_open[WIN_VSYNC]  = regs[IDX_VSYNC_OPEN];
        win_close[WIN_VSYNC] = regs[IDX_VSYNC_CLOSE];
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        lrt_window #(.W(REG_W)) u_win (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .step_en_i  (win_step[g]),
            .next_cnt_i (win_cnt[g]),
            .open_i     (win_open[g]),
            .close_i    (win_close[g]),
            .in_o       (win_q[g]),
            .in_next_o  (win_d[g])
        );
    end

    assign hdisp_on = win_q[WIN_HDISP];
    assign vdisp_on = win_q[WIN_VDISP];
    assign hsync_o  = win_q[WIN_HSYNC];
    assign vsync_o  = win_q[WIN_VSYNC];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            de_o          <= 1'b0;
            line_start_o  <= 1'b0;
            frame_start_o <= 1'b0;
        end else begin
            de_o          <= win_d[WIN_HDISP] && win_d[WIN_VDISP] && !blank_i;
            line_start_o  <= (h_next == SEED);
            frame_start_o <= (h_next == SEED) && (v_next == SEED);
        end
    end

endmodule

// File: rtl/lrt_checker.sv
module lrt_checker
    import lrt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             blank,
    input logic             de,
    input logic             line_start,
    input logic             frame_start,
    input logic [REG_W-1:0] h_cnt,
    input logic [REG_W-1:0] v_cnt,
    input logic [REG_W-1:0] xend,
    input logic             h_end,
    input logic             v_end,
    input logic             hdisp_on,
    input logic             vdisp_on
);

    localparam logic [REG_W-1:0] SEED = '1;

    a_r3_line_reload: assert property (@(posedge clk) disable iff (rst)
        (h_cnt == xend) |=> (h_cnt == SEED));

    a_r3_strobe_at_seed: assert property (@(posedge clk) disable iff (rst)
        line_start |-> (h_cnt == SEED));

    a_r4_line_holds: assert property (@(posedge clk) disable iff (rst)
        (h_cnt != xend) |=> $stable(v_cnt));

    a_r4_frame_reload: assert property (@(posedge clk) disable iff (rst)
        (h_end && v_end) |=> (v_cnt == SEED));

    a_r4_frame_in_line: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> line_start);

    a_r7_de_in_windows: assert property (@(posedge clk) disable iff (rst)
        de |-> (hdisp_on && vdisp_on));

    a_r8_blank_kills_de: assert property (@(posedge clk) disable iff (rst)
        blank |=> !de);

endmodule

bind lfsr_raster_timer lrt_checker u_chk (
    .clk         (clk_i),
    .rst         (rst_i),
    .blank       (blank_i),
    .de          (de_o),
    .line_start  (line_start_o),
    .frame_start (frame_start_o),
    .h_cnt       (h_cnt),
    .v_cnt       (v_cnt),
    .xend        (xend_state),
    .h_end       (h_end),
    .v_end       (v_end),
    .hdisp_on    (hdisp_on),
    .vdisp_on    (vdisp_on)
);

// File: tb/lfsr_raster_timer_test.sv
module lfsr_raster_timer_test;

    localparam int CLK_PERIOD = 10;

    localparam int T_HDO = 0, T_HDC = 1, T_VDO = 2, T_VDC = 3, T_LEND = 4;
    localparam int T_HSO = 5, T_HSC = 6, T_FEND = 7, T_VSO = 8, T_VSC = 9;

    logic clk = 1'b0, rst = 1'b1, blank = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00, wr_data = 8'h00;
    logic hsync, vsync, de, line_start, frame_start;

    int total = 0, bad = 0;
    bit chk_on = 1'b0;

    lfsr_raster_timer uut (
        .clk_i (clk), .rst_i (rst), .blank_i (blank),
        .wr_en_i (wr_en), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
        .hsync_o (hsync), .vsync_o (vsync), .de_o (de),
        .line_start_o (line_start), .frame_start_o (frame_start)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // R2: state after n steps from all ones
    function automatic logic [15:0] lfsr_after(input int n);
        logic [15:0] s = 16'hFFFF;
        for (int k = 0; k < n; k++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
        return s;
    endfunction

    function automatic logic [7:0] addr_of(input int idx);
        case (idx)
            T_LEND: return 8'h09;  T_FEND: return 8'h11;
            T_HDO:  return 8'h01;  T_HDC:  return 8'h03;
            T_VDO:  return 8'h05;  T_VDC:  return 8'h07;
            T_HSO:  return 8'h0B;  T_HSC:  return 8'h0D;
            T_VSO:  return 8'h13;  T_VSC:  return 8'h15;
            default: return 8'hEE;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference: binary positions, targets in positions
    int  tgt [10];
    int  hc, vc, pend_n;
    bit  f_hd, f_hs, f_vd, f_vs;
    bit  m_de, m_ls, m_fs;

    function automatic bit win_upd(input bit cur, input int n, input int op, input int cl);
        if (n == cl) return 1'b0;
        if (n == op) return 1'b1;
        return cur;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            hc = 0; vc = 0;
            f_hd = 0; f_hs = 0; f_vd = 0; f_vs = 0;
            m_de = 0; m_ls = 0; m_fs = 0;
            for (int i = 0; i < 10; i++) tgt[i] = 0;
        end else begin
            int  nhc, nvc;
            bit  wrap;
            wrap = (hc == tgt[T_LEND]);
            nhc  = wrap ? 0 : hc + 1;
            nvc  = wrap ? ((vc == tgt[T_FEND]) ? 0 : vc + 1) : vc;
            f_hd = win_upd(f_hd, nhc, tgt[T_HDO], tgt[T_HDC]);
            f_hs = win_upd(f_hs, nhc, tgt[T_HSO], tgt[T_HSC]);
            if (wrap) begin
                f_vd = win_upd(f_vd, nvc, tgt[T_VDO], tgt[T_VDC]);
                f_vs = win_upd(f_vs, nvc, tgt[T_VSO], tgt[T_VSC]);
            end
            m_de = f_hd && f_vd && !blank;
            m_ls = (nhc == 0);
            m_fs = (nhc == 0) && (nvc == 0);
            hc = nhc; vc = nvc;
            if (wr_en)
                for (int i = 0; i < 10; i++)
                    if (wr_addr == addr_of(i) + 8'd1) tgt[i] = pend_n;
        end
    end

    // per-cycle comparison, R10
    always @(negedge clk) begin
        if (chk_on) begin
            chk("R5", "hsync vs model", int'(hsync), int'(f_hs));
            chk("R6", "vsync vs model", int'(vsync), int'(f_vs));
            chk("R7", "de vs model", int'(de), int'(m_de));
            chk("R3", "line_start vs model", int'(line_start), int'(m_ls));
            chk("R4", "frame_start vs model", int'(frame_start), int'(m_fs));
        end
    end

    // R9: high byte then low byte
    task automatic wr16(input int idx, input int n);
        logic [15:0] v;
        v = lfsr_after(n);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr_of(idx); wr_data = v[15:8];
        @(negedge clk);
        wr_addr = addr_of(idx) + 8'd1; wr_data = v[7:0]; pend_n = n;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    int c_ls, c_fs, c_hs, c_vs, c_de;
    task automatic count_for(input int cycles);
        c_ls = 0; c_fs = 0; c_hs = 0; c_vs = 0; c_de = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            c_ls += int'(line_start); c_fs += int'(frame_start);
            c_hs += int'(hsync); c_vs += int'(vsync); c_de += int'(de);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "hsync in reset", int'(hsync), 0);
        chk("R1", "vsync in reset", int'(vsync), 0);
        chk("R1", "de in reset", int'(de), 0);
        chk("R1", "line_start in reset", int'(line_start), 0);
        chk("R1", "frame_start in reset", int'(frame_start), 0);
        chk_on = 1'b1;
        rst = 1'b0;

        // mode A: 20 clocks per line, 12 lines per frame
        wr16(T_HDO, 6);  wr16(T_HDC, 16);
        wr16(T_HSO, 1);  wr16(T_HSC, 4);
        wr16(T_VDO, 3);  wr16(T_VDC, 10);
        wr16(T_VSO, 0);  wr16(T_VSC, 2);
        wr16(T_FEND, 11);
        wr16(T_LEND, 19);
        count_for(300);
        count_for(480);
        chk("R2", "line strobes in 480 clocks (line length 20)", c_ls, 24);
        chk("R3", "line strobes mode A", c_ls, 24);
        chk("R4", "frame strobes mode A", c_fs, 2);
        chk("R5", "hsync cycles mode A", c_hs, 72);
        chk("R6", "vsync cycles mode A", c_vs, 80);
        chk("R7", "de cycles mode A", c_de, 140);

        // blanking
        blank = 1'b1;
        count_for(240);
        chk("R8", "de cycles while blanked", c_de, 0);
        chk("R8", "hsync cycles while blanked", c_hs, 36);
        chk("R8", "line strobes while blanked", c_ls, 12);
        blank = 1'b0;
        count_for(240);
        chk("R8", "de cycles after blank released", c_de, 70);

        // mode B: 10 clocks per line, 5 lines, window edges on the wrap
        do_reset();
        wr16(T_HDO, 0);  wr16(T_HDC, 9);
        wr16(T_HSO, 7);  wr16(T_HSC, 7);
        wr16(T_VDO, 0);  wr16(T_VDC, 5);
        wr16(T_VSO, 1);  wr16(T_VSC, 3);
        wr16(T_FEND, 4);
        wr16(T_LEND, 9);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h0F; wr_data = 8'h00;
        @(negedge clk);
        wr_addr = 8'h10; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        count_for(100);
        count_for(100);
        chk("R9", "line strobes after unmapped writes", c_ls, 10);
        chk("R4", "frame strobes mode B", c_fs, 2);
        chk("R5", "hsync cycles with equal open/close", c_hs, 0);
        chk("R6", "vsync cycles mode B", c_vs, 40);
        chk("R7", "de cycles mode B", c_de, 90);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule